// File: doc/BRIEF.md
# Inertial threshold interrupt generator

This block watches a stream of three-axis acceleration samples and raises an interrupt when the samples meet a programmed condition. Each axis magnitude is compared with a shared 7-bit threshold, which gives one "above" and one "not above" condition per axis. Six enable bits select which of these conditions take part. A 2-bit mode field picks how they are used. In the two combination modes, any enabled condition or all enabled conditions trigger the interrupt. In the two orientation modes, the block looks for a stable direction of gravity. One of these modes pulses when the device enters a known direction. The other holds the interrupt for as long as the device stays in that direction. A four-direction option leaves the vertical axis out of the orientation search.

A duration filter requires the condition to be met on a programmed number of consecutive samples before the interrupt is recognised. A source word reports the interrupt-active bit and six per-axis flags. In latched operation, the source word freezes when the interrupt fires and stays frozen until the host reads it. The read strobe clears the interrupt. The output pin polarity is programmable.

Top module: `inertial_irq`

## Requirements
- R1: An axis is "high" when the absolute value of its signed sample is strictly greater than thr_i shifted left by SMP_W-1-THR_W bits (×16 by default). Otherwise the axis is "low", and that includes equality. Flag bit 2a is the low flag of axis a and bit 2a+1 is its high flag, with a = 0 for X, 1 for Y and 2 for Z. So the order is {zh, zl, yh, yl, xh, xl}.
- R2: With mode 00, the condition holds when any enabled flag is set. In the combination modes, the reported flags are the raw flags masked by cfg_en_i.
- R3: With mode 10, the condition holds when every enabled flag is set. With no flag enabled it never holds.
- R4: With mode 11, the condition holds while exactly one considered axis is high and its direction bit is enabled. The direction bit is the high flag for a positive sample and the low flag for a negative one, and it is the only reported flag. The interrupt stays active on every sample for which this remains true.
- R5: With mode 01, the zone test is the same, but the interrupt is active only for the sample period in which the qualified zone condition becomes true after a sample where it was false.
- R6: With cfg_4d_i set, the Z axis is left out of the orientation search. A Z-only tilt is then an unknown zone, and a tilt with X and Z both high counts as X.
- R7: With duration N, a condition is recognised on a sample only when the N samples right before it also met the condition. A non-qualifying sample restarts the count.
- R8: With cfg_latch_i set, the active bit and the flags freeze once the interrupt is active. A read strobe alone clears the active bit and leaves the flags in place until the next sample refreshes them.
- R9: With cfg_latch_i clear, the source word follows every sample and the read strobe has no effect. Without a sample or a read, the source word is unchanged.
- R10: irq_o equals the active bit when cfg_act_low_i is 0, and its inverse when cfg_act_low_i is 1.
- R11: After reset, the source word is all zero and the interrupt is inactive.
- R12: When a read strobe and a sample arrive in the same cycle during a latched interrupt, the new sample is evaluated as though the interrupt had already been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | New sample strobe, one cycle |
| smp_x_i | input | SMP_W | X sample, two's complement |
| smp_y_i | input | SMP_W | Y sample, two's complement |
| smp_z_i | input | SMP_W | Z sample, two's complement |
| cfg_en_i | input | 6 | Flag enables, order {zh,zl,yh,yl,xh,xl} |
| cfg_mode_i | input | 2 | 00 any, 01 orientation pulse, 10 all, 11 orientation level |
| cfg_4d_i | input | 1 | Leave Z out of the orientation search |
| cfg_latch_i | input | 1 | Hold the source word until read |
| cfg_act_low_i | input | 1 | Pin active low |
| thr_i | input | THR_W | Threshold magnitude |
| dur_i | input | DUR_W | Minimum consecutive qualifying samples before recognition |
| src_rd_i | input | 1 | Source word read strobe, one cycle |
| irq_o | output | 1 | Interrupt pin |
| src_o | output | 7 | {active, zh, zl, yh, yl, xh, xl} |

## Verification
Two functions can fall in the same cycle: the host's read of a latched source word, and the arrival of a new sample that qualifies. The bench first latches an X-high event with both X flags enabled. It then sends one sample that would set only the X-low flag while the word is frozen, and then issues the read and the next X-low sample together. The new sample wins if the result shows active with only the X-low flag. The read would have won if the result were inactive. Neither happened if the frozen X-high flag is still shown.

// File: rtl/inertial_irq_pkg.sv
package inertial_irq_pkg;
  localparam int unsigned NUM_AXES = 3;
  localparam int unsigned NUM_EV   = 2 * NUM_AXES;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_MOVE = 2'b01,
    MODE_ALL  = 2'b10,
    MODE_POS  = 2'b11
  } mode_e;
endpackage

// File: rtl/axis_cmp.sv
module axis_cmp #(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned THR_W = 7
) (
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic [THR_W-1:0]        thr_i,
  output logic                    hi_o,
  output logic                    lo_o,
  output logic                    neg_o
);
  // threshold aligned to the top magnitude bits below the sign
  localparam int unsigned SHIFT = SMP_W - 1 - THR_W;

  logic [SMP_W-1:0] mag;
  logic [SMP_W-1:0] lim;

  always_comb begin
    if (smp_i[SMP_W-1]) mag = SMP_W'(-smp_i);
    else                mag = SMP_W'(smp_i);
  end

  assign lim   = {1'b0, thr_i, {SHIFT{1'b0}}};
  assign hi_o  = mag > lim;
  assign lo_o  = !(mag > lim);
  assign neg_o = smp_i[SMP_W-1];
endmodule

// File: rtl/event_comb.sv
module event_comb
  import inertial_irq_pkg::*;
(
  input  logic [NUM_AXES-1:0] hi_i,
  input  logic [NUM_AXES-1:0] lo_i,
  input  logic [NUM_AXES-1:0] neg_i,
  input  logic [NUM_EV-1:0]   en_i,
  input  mode_e               mode_i,
  input  logic                four_d_i,
  output logic                cond_o,
  output logic [NUM_EV-1:0]   flags_o
);
  logic [NUM_EV-1:0]   raw;
  logic [NUM_EV-1:0]   dir;
  logic [NUM_AXES-1:0] use_ax;
  logic [NUM_AXES-1:0] hi_used;
  logic [NUM_EV-1:0]   masked;
  logic [NUM_EV-1:0]   zone;
  logic                known;
  logic                orient;

  always_comb begin
    use_ax = '1;
    use_ax[NUM_AXES-1] = !four_d_i;
  end
  assign hi_used = hi_i & use_ax;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_ax
    assign raw[2*a]   = lo_i[a];
    assign raw[2*a+1] = hi_i[a];
    assign dir[2*a]   = hi_used[a] & neg_i[a];
    assign dir[2*a+1] = hi_used[a] & ~neg_i[a];
  end

  assign masked = raw & en_i;
  assign known  = $onehot(hi_used);
  assign zone   = known ? (dir & en_i) : '0;
  assign orient = mode_i[0];

  always_comb begin
    unique case (mode_i)
      MODE_ANY:  cond_o = |masked;
      MODE_ALL:  cond_o = (en_i != '0) && (masked == en_i);
      default:   cond_o = |zone;
    endcase
    flags_o = orient ? zone : masked;
  end
endmodule

// File: rtl/dur_filter.sv
module dur_filter #(
  parameter int unsigned DUR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             cond_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             edge_i,
  output logic             fire_o
);
  localparam logic [DUR_W-1:0] RUN_MAX = '1;

  logic [DUR_W-1:0] run_q;
  logic             qual_prev_q;
  logic             qual;

  assign qual   = cond_i && (run_q >= dur_i);
  assign fire_o = edge_i ? (qual && !qual_prev_q) : qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= '0;
      qual_prev_q <= 1'b0;
    end else if (step_i) begin
      if (!cond_i)               run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      qual_prev_q <= qual;
    end
  end

  AST_RUN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !cond_i |=> run_q == '0) else $error("run count not restarted"); // R7
  AST_RUN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(run_q) && $stable(qual_prev_q)) else $error("filter moved without sample"); // R7
endmodule

// File: rtl/inertial_irq.sv
module inertial_irq
  import inertial_irq_pkg::*;
#(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned THR_W = 7,
  parameter int unsigned DUR_W = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_vld_i,
  input  logic signed [SMP_W-1:0] smp_x_i,
  input  logic signed [SMP_W-1:0] smp_y_i,
  input  logic signed [SMP_W-1:0] smp_z_i,
  input  logic [NUM_EV-1:0]       cfg_en_i,
  input  logic [1:0]              cfg_mode_i,
  input  logic                    cfg_4d_i,
  input  logic                    cfg_latch_i,
  input  logic                    cfg_act_low_i,
  input  logic [THR_W-1:0]        thr_i,
  input  logic [DUR_W-1:0]        dur_i,
  input  logic                    src_rd_i,
  output logic                    irq_o,
  output logic [NUM_EV:0]         src_o
);
  logic signed [SMP_W-1:0] smp [NUM_AXES];
  logic [NUM_AXES-1:0]     hi, lo, neg;
  logic [NUM_EV-1:0]       cur_flags;
  logic                    cond, fire, frozen;
  logic                    active_q;
  logic [NUM_EV-1:0]       flags_q;
  mode_e                   mode;

  assign smp[0] = smp_x_i;
  assign smp[1] = smp_y_i;
  assign smp[2] = smp_z_i;
  assign mode   = mode_e'(cfg_mode_i);

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_cmp
    axis_cmp #(.SMP_W(SMP_W), .THR_W(THR_W)) u_cmp (
      .smp_i (smp[a]),
      .thr_i (thr_i),
      .hi_o  (hi[a]),
      .lo_o  (lo[a]),
      .neg_o (neg[a])
    );
  end

  event_comb u_comb (
    .hi_i     (hi),
    .lo_i     (lo),
    .neg_i    (neg),
    .en_i     (cfg_en_i),
    .mode_i   (mode),
    .four_d_i (cfg_4d_i),
    .cond_o   (cond),
    .flags_o  (cur_flags)
  );

  dur_filter #(.DUR_W(DUR_W)) u_dur (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (smp_vld_i),
    .cond_i (cond),
    .dur_i  (dur_i),
    .edge_i (mode == MODE_MOVE),
    .fire_o (fire)
  );

  // a read in the same cycle unfreezes, so a coincident sample is taken
  assign frozen = cfg_latch_i && active_q && !src_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      flags_q  <= '0;
    end else if (smp_vld_i && !frozen) begin
      active_q <= fire;
      flags_q  <= cur_flags;
    end else if (src_rd_i && cfg_latch_i) begin
      active_q <= 1'b0;
    end
  end

  assign src_o = {active_q, flags_q};
  assign irq_o = active_q ^ cfg_act_low_i;

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_latch_i && src_rd_i && !smp_vld_i |=> !src_o[NUM_EV]) else $error("read left interrupt set"); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_latch_i && src_o[NUM_EV] && !src_rd_i |=> src_o[NUM_EV] && $stable(src_o)) else $error("latched word moved"); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i && !src_rd_i |=> $stable(src_o)) else $error("source changed without cause"); // R9
  AST_ZONE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && cfg_mode_i[0] |-> $onehot0(cur_flags)) else $error("more than one zone flag"); // R4
  AST_ALL_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && !frozen && cfg_mode_i == 2'b10 && cfg_en_i == '0 |=> !src_o[NUM_EV]) else $error("empty all-mode fired"); // R3
endmodule

// File: tb/inertial_irq_tb_top.sv
`timescale 1ns/1ps
module inertial_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, rd = 1'b0;
  logic signed [11:0] sx = '0, sy = '0, sz = '0;
  logic [5:0] en = '0;
  logic [1:0] mode = '0;
  logic f4d = 1'b0, latch = 1'b0, act_low = 1'b0;
  logic [6:0] thr = 7'd32;
  logic [6:0] dur = '0;
  logic irq;
  logic [6:0] src;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  inertial_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld),
    .smp_x_i(sx), .smp_y_i(sy), .smp_z_i(sz),
    .cfg_en_i(en), .cfg_mode_i(mode), .cfg_4d_i(f4d),
    .cfg_latch_i(latch), .cfg_act_low_i(act_low),
    .thr_i(thr), .dur_i(dur), .src_rd_i(rd),
    .irq_o(irq), .src_o(src)
  );

  typedef struct packed {
    logic [1:0]        md;
    logic              d4;
    logic [5:0]        ena;
    logic signed [11:0] x;
    logic signed [11:0] y;
    logic signed [11:0] z;
    logic [6:0]        exp;
    logic [3:0]        req;
  } vec_t;

  // threshold 32 -> limit 512; exp = {active, zh,zl,yh,yl,xh,xl}
  localparam vec_t TBL [18] = '{
    '{2'b00, 1'b0, 6'b000010,  12'sd600,    12'sd0,    12'sd0, 7'b1000010, 4'd1}, // R1 above
    '{2'b00, 1'b0, 6'b000010,  12'sd512,    12'sd0,    12'sd0, 7'b0000000, 4'd1}, // R1 equal is low
    '{2'b00, 1'b0, 6'b000010, -12'sd513,    12'sd0,    12'sd0, 7'b1000010, 4'd1}, // R1 magnitude
    '{2'b00, 1'b0, 6'b010101,  12'sd100,  12'sd700,    12'sd0, 7'b1010001, 4'd2}, // R2 any
    '{2'b10, 1'b0, 6'b010101,  12'sd100,  12'sd700,    12'sd0, 7'b0010001, 4'd3}, // R3 not all
    '{2'b10, 1'b0, 6'b010101,  12'sd100,   -12'sd5,  12'sd512, 7'b1010101, 4'd3}, // R3 all
    '{2'b10, 1'b0, 6'b000000,    12'sd0,    12'sd0,    12'sd0, 7'b0000000, 4'd3}, // R3 none enabled
    '{2'b11, 1'b0, 6'b111111,    12'sd0,    12'sd0,  12'sd900, 7'b1100000, 4'd4}, // R4 Z up
    '{2'b11, 1'b0, 6'b111111,    12'sd0,    12'sd0,  12'sd900, 7'b1100000, 4'd4}, // R4 held
    '{2'b11, 1'b0, 6'b111111,    12'sd0, -12'sd800,    12'sd0, 7'b1000100, 4'd4}, // R4 Y down
    '{2'b11, 1'b0, 6'b111111,  12'sd600,  12'sd600,    12'sd0, 7'b0000000, 4'd4}, // R4 two axes
    '{2'b11, 1'b0, 6'b111110, -12'sd700,    12'sd0,    12'sd0, 7'b0000000, 4'd4}, // R4 disabled dir
    '{2'b01, 1'b0, 6'b111111,    12'sd0,    12'sd0, -12'sd900, 7'b1010000, 4'd5}, // R5 entry
    '{2'b01, 1'b0, 6'b111111,    12'sd0,    12'sd0, -12'sd900, 7'b0010000, 4'd5}, // R5 one period
    '{2'b01, 1'b0, 6'b111111,    12'sd0,    12'sd0,    12'sd0, 7'b0000000, 4'd5}, // R5 unknown
    '{2'b01, 1'b0, 6'b111111,    12'sd0,  12'sd900,    12'sd0, 7'b1001000, 4'd5}, // R5 re-entry
    '{2'b11, 1'b1, 6'b111111,    12'sd0,    12'sd0,  12'sd900, 7'b0000000, 4'd6}, // R6 Z ignored
    '{2'b11, 1'b1, 6'b111111,  12'sd700,    12'sd0,  12'sd900, 7'b1000010, 4'd6}  // R6 X with Z
  };

  task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // one-cycle sample (and optional read); outputs settle after the edge
  task automatic step(input logic signed [11:0] x, input logic signed [11:0] y,
                      input logic signed [11:0] z, input logic do_smp, input logic do_rd);
    @(negedge clk);
    sx = x; sy = y; sz = z; vld = do_smp; rd = do_rd;
    @(negedge clk);
    vld = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset src", src, 7'd0);
    chk("R11 reset pin", {6'd0, irq}, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    act_low = 1'b1; #1;
    chk("R10 idle pin low-active", {6'd0, irq}, 7'd1);
    act_low = 1'b0;

    for (int i = 0; i < 18; i++) begin
      mode = TBL[i].md; f4d = TBL[i].d4; en = TBL[i].ena;
      step(TBL[i].x, TBL[i].y, TBL[i].z, 1'b1, 1'b0);
      chk($sformatf("R%0d vector %0d", TBL[i].req, i), src, TBL[i].exp);
    end
    f4d = 1'b0;

    // R7 duration 3: fires on the 4th consecutive qualifying sample
    mode = 2'b00; en = 6'b000010;
    step(12'sd0, 12'sd0, 12'sd0, 1'b1, 1'b0);
    dur = 7'd3;
    for (int k = 0; k < 3; k++) begin
      step(12'sd600, 12'sd0, 12'sd0, 1'b1, 1'b0);
      chk("R7 before count", {src[6], 6'd0}, 7'd0);
    end
    step(12'sd600, 12'sd0, 12'sd0, 1'b1, 1'b0);
    chk("R7 count reached", src, 7'b1000010);
    step(12'sd0, 12'sd0, 12'sd0, 1'b1, 1'b0);
    step(12'sd600, 12'sd0, 12'sd0, 1'b1, 1'b0);
    chk("R7 count restarted", {src[6], 6'd0}, 7'd0);
    dur = '0;

    // R9 read has no effect without latching
    step(12'sd600, 12'sd0, 12'sd0, 1'b1, 1'b0);
    step(12'sd0, 12'sd0, 12'sd0, 1'b0, 1'b1);
    chk("R9 read ignored", src, 7'b1000010);
    act_low = 1'b1; #1;
    chk("R10 active pin low", {6'd0, irq}, 7'd0);
    act_low = 1'b0;

    // R8 latch and read
    latch = 1'b1;
    step(12'sd600, 12'sd0, 12'sd0, 1'b1, 1'b0);
    step(12'sd0, 12'sd0, 12'sd0, 1'b1, 1'b0);
    chk("R8 frozen", src, 7'b1000010);
    step(12'sd0, 12'sd0, 12'sd0, 1'b0, 1'b1);
    chk("R8 read clears active", src, 7'b0000010);
    step(12'sd0, 12'sd0, 12'sd0, 1'b1, 1'b0);
    chk("R8 flags refresh", src, 7'b0000000);

    // R12 read and sample together: new sample wins
    en = 6'b000011;
    step(12'sd600, 12'sd0, 12'sd0, 1'b1, 1'b0);
    chk("R12 setup latch", src, 7'b1000010);
    step(12'sd0, 12'sd0, 12'sd0, 1'b1, 1'b0);
    chk("R12 setup frozen", src, 7'b1000010);
    step(12'sd0, 12'sd0, 12'sd0, 1'b1, 1'b1);
    chk("R12 sample over read", src, 7'b1000001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule